// File: doc/BRIEF.md
# Five-State Multicycle Accumulator Processor

This block is a small 8-bit processor that executes a two-operand instruction set with register add, register copy, literal load, direct-address load, direct-address store and halt. Each instruction takes the same fixed walk through five states, one clock each: fetch, decode with register read, ALU, memory access and register write-back. An instruction that has nothing to do in a state still spends that clock there.

The machine holds four 8-bit working registers (called AX, BX, CX and DX, indices 0 to 3), an 8-bit instruction pointer, a 16-bit instruction register, a memory address register and a memory data register. Instruction memory and data memory are separate arrays of 16 entries each. A bench fills both memories through a load port while reset is held. After reset is released, the processor runs until it executes a halt.

A debug interface shows the current state, the instruction pointer, the four registers and the halt flag, and gives a read-only view of any data memory word. A bench can therefore follow a reference model one cycle at a time.

Top module: `mcpu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the state goes to fetch (code 0), the instruction pointer and all four registers go to 0, and the halt flag is cleared.
- R2: Outside halt, the state follows the order fetch(0), decode(1), ALU(2), memory(3), write-back(4) and then back to fetch, spending exactly one cycle in each, for every opcode including the register-only ones.
- R3: The instruction pointer rises by one (modulo 256) on the edge that leaves fetch and holds its value in every other state. Instruction memory is indexed by its low 4 bits.
- R4: Opcode 0 (add) writes rd + rs modulo 256 into rd, the first-named register, and leaves the other registers alone.
- R5: Opcode 1 (literal load) writes the 8-bit immediate field into rd.
- R6: Opcode 2 (direct load) writes into rd the data memory word at the low 4 bits of the immediate field.
- R7: Opcode 3 (store) writes register rd into the data memory word at the low 4 bits of the immediate field, changes no register, and writes memory only in the memory-access state.
- R8: Opcode 4 (register copy) writes rs into rd.
- R9: Registers change only on the edge that leaves write-back. Their values seen in any earlier state of an instruction equal those before it.
- R10: Opcode 7 (halt) passes through all five states and then sets the halt flag. After that the state stays at fetch, and the instruction pointer, registers and memory stay frozen until reset.
- R11: The instruction word is {opcode[15:13], rd[12:11], rs[10:9], spare[8], imm[7:0]}. The spare bit has no effect, and opcodes 5 and 6 complete five states with no register or memory change.
- R12: The load port writes instruction memory (all 16 bits of `ld_data`) or data memory (`ld_data[7:0]`) only while `rst` is high. When `rst` is low, its write enables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_imem_we | input | 1 | Load-port write enable for instruction memory |
| ld_dmem_we | input | 1 | Load-port write enable for data memory |
| ld_addr | input | 4 | Load-port word address |
| ld_data | input | 16 | Load-port write data |
| dbg_daddr | input | 4 | Data memory address for the debug read |
| dbg_ddata | output | 8 | Data memory word at `dbg_daddr` |
| dbg_state | output | 3 | Current cycle state code (0 to 4) |
| dbg_ip | output | 8 | Instruction pointer |
| dbg_regs | output | 32 | Registers, register i at bits [8i+7:8i] |
| dbg_halted | output | 1 | Halt flag |

## Verification
The bench goes after add overflow and add with a register onto itself. A design that carried out of eight bits, or that read rd after writing it, would leave the wrong sum. It stores to an address whose upper immediate bits are set and then loads it back, which exposes any design that uses the full immediate as the index. It also puts halts at address 0 and mid-program, which catches a design that keeps stepping the instruction pointer or still writes after halting. Finally, it holds the load-port enables high while the program runs. A design that did not gate them with reset would overwrite both a pending instruction and a data word.

// File: rtl/mcpu_pkg.sv
`timescale 1ns/1ps
package mcpu_pkg;

  localparam int DATA_W  = 8;
  localparam int INSTR_W = 16;
  localparam int NREG    = 4;
  localparam int RIDX_W  = $clog2(NREG);
  localparam int OPC_W   = 3;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_ALU    = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } cyc_state_t;

  localparam logic [OPC_W-1:0] OPC_ADD   = 3'd0;
  localparam logic [OPC_W-1:0] OPC_MOVI  = 3'd1;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 3'd2;
  localparam logic [OPC_W-1:0] OPC_STORE = 3'd3;
  localparam logic [OPC_W-1:0] OPC_MOVR  = 3'd4;
  localparam logic [OPC_W-1:0] OPC_HALT  = 3'd7;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic              spare;
    logic [DATA_W-1:0] imm;
    logic              wr_reg;
    logic              use_mdr;
    logic              mem_rd;
    logic              mem_wr;
    logic              halt;
  } dec_t;

  // Split an instruction word into fields and derive control flags.
  function automatic dec_t decode_instr(input logic [INSTR_W-1:0] w);
    dec_t d;
    d.opc     = w[15:13];
    d.rd      = w[12:11];
    d.rs      = w[10:9];
    d.spare   = w[8];
    d.imm     = w[7:0];
    d.wr_reg  = (d.opc == OPC_ADD) || (d.opc == OPC_MOVI) ||
                (d.opc == OPC_LOAD) || (d.opc == OPC_MOVR);
    d.use_mdr = (d.opc == OPC_LOAD);
    d.mem_rd  = (d.opc == OPC_LOAD);
    d.mem_wr  = (d.opc == OPC_STORE);
    d.halt    = (d.opc == OPC_HALT);
    return d;
  endfunction

  // Value produced in the ALU state for register-writing opcodes.
  function automatic logic [DATA_W-1:0] alu_calc(
      input logic [OPC_W-1:0]  opc,
      input logic [DATA_W-1:0] a,
      input logic [DATA_W-1:0] b,
      input logic [DATA_W-1:0] imm);
    logic [DATA_W-1:0] r;
    case (opc)
      OPC_ADD:  r = a + b;
      OPC_MOVI: r = imm;
      OPC_MOVR: r = b;
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mcpu_ram.sv
`timescale 1ns/1ps
module mcpu_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [WIDTH-1:0]     wdata,
  input  logic [NRD*AW-1:0]    raddr,
  output logic [NRD*WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p*WIDTH +: WIDTH] = mem[raddr[p*AW +: AW]];
  end

endmodule

// File: rtl/mcpu_regfile.sv
`timescale 1ns/1ps
module mcpu_regfile #(
  parameter int NREG  = 4,
  parameter int WIDTH = 8,
  localparam int IW   = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IW-1:0]         waddr,
  input  logic [WIDTH-1:0]      wdata,
  input  logic [IW-1:0]         raddr_a,
  input  logic [IW-1:0]         raddr_b,
  output logic [WIDTH-1:0]      rdata_a,
  output logic [WIDTH-1:0]      rdata_b,
  output logic [NREG*WIDTH-1:0] flat
);

  logic [WIDTH-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                             regs[g] <= '0;
      else if (we && (waddr == IW'(g)))    regs[g] <= wdata;
    end
    assign flat[g*WIDTH +: WIDTH] = regs[g];
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mcpu_ctrl.sv
`timescale 1ns/1ps
module mcpu_ctrl
  import mcpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req,
  output cyc_state_t state,
  output logic       halted,
  output logic       fetch_fire,
  output logic       decode_fire,
  output logic       alu_fire,
  output logic       mem_fire,
  output logic       wb_fire
);

  cyc_state_t state_nxt;

  assign fetch_fire  = (state == ST_FETCH) && !halted;
  assign decode_fire = (state == ST_DECODE);
  assign alu_fire    = (state == ST_ALU);
  assign mem_fire    = (state == ST_MEM);
  assign wb_fire     = (state == ST_WB);

  always_comb begin
    unique case (state)
      ST_FETCH:  state_nxt = halted ? ST_FETCH : ST_DECODE;
      ST_DECODE: state_nxt = ST_ALU;
      ST_ALU:    state_nxt = ST_MEM;
      ST_MEM:    state_nxt = ST_WB;
      ST_WB:     state_nxt = ST_FETCH;
      default:   state_nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      halted <= 1'b0;
    end else begin
      state <= state_nxt;
      if (wb_fire && halt_req) halted <= 1'b1;
    end
  end

endmodule

// File: rtl/mcpu_top.sv
`timescale 1ns/1ps
module mcpu_top
  import mcpu_pkg::*;
#(
  parameter int MEM_DEPTH = 16,
  localparam int MAW      = $clog2(MEM_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_imem_we,
  input  logic                   ld_dmem_we,
  input  logic [MAW-1:0]         ld_addr,
  input  logic [INSTR_W-1:0]     ld_data,
  input  logic [MAW-1:0]         dbg_daddr,
  output logic [DATA_W-1:0]      dbg_ddata,
  output logic [2:0]             dbg_state,
  output logic [DATA_W-1:0]      dbg_ip,
  output logic [NREG*DATA_W-1:0] dbg_regs,
  output logic                   dbg_halted
);

  // Architectural and pipeline-stage registers
  logic [INSTR_W-1:0] ir;
  logic [DATA_W-1:0]  ip;
  logic [DATA_W-1:0]  opa, opb, res;
  logic [MAW-1:0]     mar;
  logic [DATA_W-1:0]  mdr;

  // Named internal events, also seen by the checker
  cyc_state_t state;
  logic       halted;
  logic       fetch_fire, decode_fire, alu_fire, mem_fire, wb_fire;
  logic       rf_we;
  logic       cpu_dmem_we;

  dec_t dec;
  logic dec_spare_unused;
  assign dec = decode_instr(ir);
  assign dec_spare_unused = dec.spare;

  mcpu_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (dec.halt),
    .state      (state),
    .halted     (halted),
    .fetch_fire (fetch_fire),
    .decode_fire(decode_fire),
    .alu_fire   (alu_fire),
    .mem_fire   (mem_fire),
    .wb_fire    (wb_fire)
  );

  // Instruction memory: written only by the load port under reset
  logic               imem_we;
  logic [INSTR_W-1:0] imem_q;
  assign imem_we = rst && ld_imem_we;

  mcpu_ram #(.WIDTH(INSTR_W), .DEPTH(MEM_DEPTH), .NRD(1)) u_imem (
    .clk  (clk),
    .we   (imem_we),
    .waddr(ld_addr),
    .wdata(ld_data),
    .raddr(ip[MAW-1:0]),
    .rdata(imem_q)
  );

  // Data memory: load port under reset, processor store otherwise
  logic              dmem_we;
  logic [MAW-1:0]    dmem_waddr;
  logic [DATA_W-1:0] dmem_wdata;
  logic [DATA_W-1:0] dmem_q;

  assign cpu_dmem_we = mem_fire && dec.mem_wr;
  assign dmem_we     = (rst && ld_dmem_we) || cpu_dmem_we;
  assign dmem_waddr  = rst ? ld_addr : mar;
  assign dmem_wdata  = rst ? ld_data[DATA_W-1:0] : mdr;

  mcpu_ram #(.WIDTH(DATA_W), .DEPTH(MEM_DEPTH), .NRD(2)) u_dmem (
    .clk  (clk),
    .we   (dmem_we),
    .waddr(dmem_waddr),
    .wdata(dmem_wdata),
    .raddr({dbg_daddr, mar}),
    .rdata({dbg_ddata, dmem_q})
  );

  // Register file
  logic [DATA_W-1:0] rf_a, rf_b, rf_wdata;
  assign rf_we    = wb_fire && dec.wr_reg;
  assign rf_wdata = dec.use_mdr ? mdr : res;

  mcpu_regfile #(.NREG(NREG), .WIDTH(DATA_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (dec.rd),
    .wdata  (rf_wdata),
    .raddr_a(dec.rd),
    .raddr_b(dec.rs),
    .rdata_a(rf_a),
    .rdata_b(rf_b),
    .flat   (dbg_regs)
  );

  // Datapath stepping, one stage per state
  always_ff @(posedge clk) begin
    if (rst) begin
      ir  <= '0;
      ip  <= '0;
      opa <= '0;
      opb <= '0;
      res <= '0;
      mar <= '0;
      mdr <= '0;
    end else begin
      if (fetch_fire) begin
        ir <= imem_q;
        ip <= ip + 1'b1;
      end
      if (decode_fire) begin
        opa <= rf_a;
        opb <= rf_b;
      end
      if (alu_fire) begin
        res <= alu_calc(dec.opc, opa, opb, dec.imm);
        mar <= dec.imm[MAW-1:0];
        if (dec.mem_wr) mdr <= opa;
      end
      if (mem_fire && dec.mem_rd) begin
        mdr <= dmem_q;
      end
    end
  end

  assign dbg_state  = state;
  assign dbg_ip     = ip;
  assign dbg_halted = halted;

endmodule

// File: rtl/mcpu_checker.sv
`timescale 1ns/1ps
module mcpu_checker
  import mcpu_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic [2:0]             state,
  input logic [DATA_W-1:0]      ip,
  input logic                   halted,
  input logic                   rf_we,
  input logic                   dmem_we,
  input logic [NREG*DATA_W-1:0] regs
);

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && !halted) |=> state == ST_DECODE); // R2
  AST_DECODE_TO_ALU: assert property (@(posedge clk) disable iff (rst)
    state == ST_DECODE |=> state == ST_ALU); // R2
  AST_ALU_TO_MEM: assert property (@(posedge clk) disable iff (rst)
    state == ST_ALU |=> state == ST_MEM); // R2
  AST_MEM_TO_WB: assert property (@(posedge clk) disable iff (rst)
    state == ST_MEM |=> state == ST_WB); // R2
  AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    state == ST_WB |=> state == ST_FETCH); // R2
  AST_IP_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && !halted) |=> ip == DATA_W'($past(ip) + 1)); // R3
  AST_IP_HOLD: assert property (@(posedge clk) disable iff (rst)
    state != ST_FETCH |=> $stable(ip)); // R3
  AST_RF_WRITE_IN_WB: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> state == ST_WB); // R9
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    state != ST_WB |=> $stable(regs)); // R9
  AST_STORE_IN_MEM: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> state == ST_MEM); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && state == ST_FETCH && $stable(ip) && $stable(regs))); // R10
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!rf_we && !dmem_we)); // R10

endmodule

bind mcpu_top mcpu_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .state  (dbg_state),
  .ip     (dbg_ip),
  .halted (dbg_halted),
  .rf_we  (rf_we),
  .dmem_we(cpu_dmem_we),
  .regs   (dbg_regs)
);

// File: tb/mcpu_top_tb_top.sv
`timescale 1ns/1ps
module mcpu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [3:0]  ld_addr = '0, dbg_daddr = '0;
  logic [15:0] ld_data = '0;
  logic [7:0]  dbg_ddata, dbg_ip;
  logic [2:0]  dbg_state;
  logic [31:0] dbg_regs;
  logic        dbg_halted;

  always #2.5 clk = ~clk;

  mcpu_top dut_i (
    .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_daddr(dbg_daddr),
    .dbg_ddata(dbg_ddata), .dbg_state(dbg_state), .dbg_ip(dbg_ip),
    .dbg_regs(dbg_regs), .dbg_halted(dbg_halted)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Reference machine state
  logic [15:0] m_imem [16];
  logic [7:0]  m_dmem [16];
  logic [7:0]  m_reg  [4];
  logic [7:0]  m_ip;
  bit          m_halt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int opc, input int rd, input int rs,
                                      input bit spare, input logic [7:0] imm);
    return {3'(opc), 2'(rd), 2'(rs), spare, imm};
  endfunction

  function automatic logic [31:0] m_flat();
    return {m_reg[3], m_reg[2], m_reg[1], m_reg[0]};
  endfunction

  function automatic string req_of(input logic [2:0] opc);
    case (opc)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd7: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Instruction-level reference: one whole instruction at a time
  task automatic model_step();
    logic [15:0] w;
    int rd, rs;
    w  = m_imem[m_ip[3:0]];
    rd = int'(w[12:11]);
    rs = int'(w[10:9]);
    m_ip = m_ip + 8'd1;
    case (w[15:13])
      3'd0: m_reg[rd] = m_reg[rd] + m_reg[rs];
      3'd1: m_reg[rd] = w[7:0];
      3'd2: m_reg[rd] = m_dmem[w[3:0]];
      3'd3: m_dmem[w[3:0]] = m_reg[rd];
      3'd4: m_reg[rd] = m_reg[rs];
      3'd7: m_halt = 1'b1;
      default: ;
    endcase
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst = 1'b1;
    ld_dmem_we = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ld_imem_we = 1'b1; ld_addr = 4'(i); ld_data = m_imem[i];
      @(negedge clk);
    end
    ld_imem_we = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ld_dmem_we = 1'b1; ld_addr = 4'(i); ld_data = {8'h00, m_dmem[i]};
      @(negedge clk);
    end
    ld_dmem_we = 1'b0;
    @(negedge clk);
    // R1: reset state seen while reset is held
    chk(dbg_state == 3'd0 && dbg_ip == 8'd0 && dbg_regs == 32'd0 && !dbg_halted,
        "R1", "reset state", {dbg_halted, dbg_state, dbg_ip, dbg_regs}, 64'd0);
    for (int i = 0; i < 4; i++) m_reg[i] = 8'd0;
    m_ip = 8'd0;
    m_halt = 1'b0;
    rst = 1'b0;
  endtask

  task automatic run_prog(input bit leak_test);
    int guard = 0;
    while (!m_halt && guard < 40) begin
      logic [15:0] w;
      logic [31:0] old_flat;
      bit seq_ok;
      string req;
      guard++;
      w = m_imem[m_ip[3:0]];
      req = req_of(w[15:13]);
      old_flat = m_flat();
      seq_ok = (dbg_state == 3'd0) && (dbg_ip == m_ip);
      for (int k = 1; k <= 4; k++) begin
        @(posedge clk); @(negedge clk);
        seq_ok = seq_ok && (dbg_state == 3'(k));
        if (k == 1)
          chk(dbg_ip == m_ip + 8'd1, "R3", "ip after fetch", dbg_ip, m_ip + 8'd1);
        if (k == 4)
          chk(dbg_regs == old_flat, "R9", "regs before write-back", dbg_regs, old_flat);
      end
      chk(seq_ok, "R2", "five-state order", dbg_state, 3'd4);
      model_step();
      @(posedge clk); @(negedge clk);
      chk(dbg_regs == m_flat() && dbg_ip == m_ip && dbg_state == 3'd0, req,
          "instruction result", {dbg_state, dbg_ip, dbg_regs}, {3'd0, m_ip, m_flat()});
    end
    // R10: frozen after halt
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      chk(dbg_halted && dbg_state == 3'd0 && dbg_ip == m_ip && dbg_regs == m_flat(),
          "R10", "halt freeze", {dbg_halted, dbg_state, dbg_ip, dbg_regs},
          {1'b1, 3'd0, m_ip, m_flat()});
    end
    ld_imem_we = 1'b0;
    ld_dmem_we = 1'b0;
    for (int i = 0; i < 16; i++) begin
      dbg_daddr = 4'(i);
      @(negedge clk);
      chk(dbg_ddata == m_dmem[i], (leak_test && i == 2) ? "R12" : "R7",
          $sformatf("dmem[%0d]", i), dbg_ddata, m_dmem[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));

    // Directed program: overflow, copy, store/load round trip, self-add,
    // undefined opcode, spare bit, upper address bits, halt.
    m_imem[0]  = enc(1, 0, 0, 0, 8'h8C);
    m_imem[1]  = enc(1, 1, 0, 0, 8'h9A);
    m_imem[2]  = enc(0, 0, 1, 0, 8'h00);   // R4 wrap: 8C+9A = 26
    m_imem[3]  = enc(4, 2, 0, 0, 8'h00);   // R8
    m_imem[4]  = enc(3, 2, 0, 0, 8'h05);   // R7
    m_imem[5]  = enc(2, 3, 0, 0, 8'h05);   // R6
    m_imem[6]  = enc(2, 1, 0, 0, 8'h0F);
    m_imem[7]  = enc(0, 3, 3, 0, 8'h00);
    m_imem[8]  = enc(5, 1, 2, 1, 8'hFF);   // R11 undefined opcode
    m_imem[9]  = enc(1, 0, 0, 1, 8'h11);   // R11 spare bit set
    m_imem[10] = enc(3, 0, 0, 0, 8'h25);   // R7 low 4 address bits
    m_imem[11] = enc(7, 0, 0, 0, 8'h00);   // R10
    for (int i = 12; i < 16; i++) m_imem[i] = enc(1, 0, 0, 0, 8'hFF);
    for (int i = 0; i < 16; i++) m_dmem[i] = 8'(i * 17 + 3);
    load_and_reset();
    // R12: load-port enables held while running must be ignored
    ld_imem_we = 1'b1; ld_dmem_we = 1'b1; ld_addr = 4'd2; ld_data = 16'h20EE;
    run_prog(1'b1);

    // Halt as the very first instruction
    for (int i = 0; i < 16; i++) m_imem[i] = enc(7, 0, 0, 0, 8'h00);
    load_and_reset();
    run_prog(1'b0);

    // Constrained random programs ending in halt
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 15; i++) begin
        int opc = int'($urandom_range(0, 7));
        if (opc == 7) opc = 0;
        m_imem[i] = enc(opc, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                        1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
      end
      m_imem[15] = enc(7, 0, 0, 0, 8'h00);
      for (int i = 0; i < 16; i++) m_dmem[i] = 8'($urandom_range(0, 255));
      load_and_reset();
      run_prog(1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule